// File: doc/BRIEF.md
# Character Display Parallel Bus Engine

This block is the host-side driver for the parallel bus of a character display module. A client hands it one request: a register-select bit, a read/write bit, a data byte and a flag that selects 4-bit or 8-bit transfers. The engine then sequences the register-select, read/write and enable lines and the data bus so that every timing minimum of the display is met. Each minimum is given in nanoseconds and converted to a count of system clocks. For reads it captures the byte the display returns. For either direction it pulses a completion flag when the transfer is over.

In 4-bit mode each byte becomes two enable strobes. Only the upper four bus lines carry data, the high nibble goes first, and read data is built up from the two strobes. Deciding when to poll the busy flag and which commands to issue is the job of the client. The register-select bit is passed through unchanged: low addresses the instruction side and high the data side, and a read with select low returns busy in bit 7 and the address counter in bits 6..0.

Top module: `lcd_bus_engine`

## Requirements
- R1: Out of reset, the enable line and data-bus output enable are low, `req_ready` is high and `done` is low.
- R2: A request is taken only in a cycle where `req_ready` is high. While a transfer is running, `req_valid` is ignored: the strobe count, bus value and select lines of the running transfer do not change.
- R3: `lcd_rs` and `lcd_rw` equal the request's select and direction bits for every strobe of the transfer (select 0 = instruction side, 1 = data side; direction 1 = read).
- R4: The enable line rises exactly SU clocks after acceptance. SU is ceil(T_SETUP_NS·CLK_MHZ/1000), with a minimum of 1 (28 at default).
- R5: Each enable-high pulse lasts HI clocks, where HI is the larger of the converted high-width minimum and one more than the converted read-valid delay (46 at default). Select, direction and bus do not change while enable is high.
- R6: Consecutive enable rising edges, inside one transfer and across back-to-back transfers, are at least the converted cycle minimum apart (100 at default).
- R7: After enable falls, select, direction, bus value and bus output enable stay unchanged for at least the converted hold count (2 at default).
- R8: The bus output enable is high only during a write transfer. In 8-bit mode the full request byte is driven on `lcd_db_out[7:0]`.
- R9: In 4-bit mode a transfer makes two strobes. The first drives data[7:4] on `lcd_db_out[7:4]` and the second drives data[3:0] there, with `lcd_db_out[3:0]` held at zero.
- R10: An 8-bit read returns on `rd_data` the bus value present at the last clock of the enable-high phase.
- R11: A 4-bit read returns {first strobe's `lcd_db_in[7:4]`, second strobe's `lcd_db_in[7:4]`}. Bits [3:0] of the bus input are ignored.
- R12: `done` is a single-cycle pulse that rises SU+HI+LO clocks per strobe after acceptance (100 for 8-bit and 200 for 4-bit at default), in the same cycle `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_rs | input | 1 | Register select for the request |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_nibble | input | 1 | 1 = 4-bit transfer, 0 = 8-bit |
| req_data | input | 8 | Write byte |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read from the display |
| lcd_rs | output | 1 | Display register-select line |
| lcd_rw | output | 1 | Display read/write line |
| lcd_e | output | 1 | Display enable strobe |
| lcd_db_out | output | 8 | Data bus drive value |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_in | input | 8 | Data bus value from the display |

## Verification
The completion pulse of one transfer and the acceptance of the next can fall in the same cycle, because `done` rises together with `req_ready`. The bench provokes this by waiting for `done` and presenting a new request in that very cycle. It then judges that acceptance came exactly one sample after the pulse. It also checks that only one completion was reported per transfer and that the enable rise-to-rise spacing across the boundary still meets the cycle minimum.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } phase_e;

  // Nanoseconds to clocks, rounded up, never below one clock.
  function automatic int ns_to_clk(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_bus_pkg::*;
#(
  parameter int SU_CYC = 28,
  parameter int HI_CYC = 46,
  parameter int LO_CYC = 26,
  parameter int TW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_nibble,
  input  logic          expired,
  output logic          load,
  output logic [TW-1:0] load_val,
  output phase_e        phase,
  output logic          second,
  output logic          nibble_mode,
  output logic          accept,
  output logic          sample,
  output logic          ready,
  output logic          done
);

  localparam logic [TW-1:0] SU_LD = TW'(SU_CYC - 1);
  localparam logic [TW-1:0] HI_LD = TW'(HI_CYC - 1);
  localparam logic [TW-1:0] LO_LD = TW'(LO_CYC - 1);

  phase_e ph_q, ph_d;
  logic   second_q, second_d;
  logic   mode_q, mode_d;
  logic   done_q, done_d;

  assign ready  = (ph_q == PH_IDLE);
  assign accept = ready & req_valid;

  always_comb begin
    ph_d     = ph_q;
    second_d = second_q;
    mode_d   = mode_q;
    done_d   = 1'b0;
    load     = 1'b0;
    load_val = SU_LD;
    sample   = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d     = PH_SETUP;
        second_d = 1'b0;
        mode_d   = req_nibble;
        load     = 1'b1;
        load_val = SU_LD;
      end
      PH_SETUP: if (expired) begin
        ph_d     = PH_HIGH;
        load     = 1'b1;
        load_val = HI_LD;
      end
      PH_HIGH: if (expired) begin
        ph_d     = PH_LOW;
        sample   = 1'b1;
        load     = 1'b1;
        load_val = LO_LD;
      end
      PH_LOW: if (expired) begin
        if (mode_q && !second_q) begin
          ph_d     = PH_SETUP;
          second_d = 1'b1;
          load     = 1'b1;
          load_val = SU_LD;
        end else begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      second_q <= 1'b0;
      mode_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      second_q <= second_d;
      mode_q   <= mode_d;
      done_q   <= done_d;
    end
  end

  assign phase       = ph_q;
  assign second      = second_q;
  assign nibble_mode = mode_q;
  assign done        = done_q;

endmodule

// File: rtl/lcd_data_lane.sv
module lcd_data_lane
  import lcd_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [7:0] req_data,
  input  phase_e     phase,
  input  logic       second,
  input  logic       nibble_mode,
  input  logic       sample,
  input  logic [7:0] db_in,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic [7:0] db_out,
  output logic       db_oe,
  output logic [7:0] rd_data
);

  logic       rs_q, rw_q;
  logic [7:0] wdat_q;
  logic [7:0] rd_q, rd_d;

  always_comb begin
    rd_d = rd_q;
    if (sample) begin
      if (!nibble_mode)  rd_d        = db_in;
      else if (!second)  rd_d[7:4]   = db_in[7:4];
      else               rd_d[3:0]   = db_in[7:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q   <= 1'b0;
      rw_q   <= 1'b0;
      wdat_q <= '0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        rs_q   <= req_rs;
        rw_q   <= req_rw;
        wdat_q <= req_data;
      end
      rd_q <= rd_d;
    end
  end

  always_comb begin
    if (!nibble_mode)  db_out = wdat_q;
    else if (!second)  db_out = {wdat_q[7:4], 4'b0000};
    else               db_out = {wdat_q[3:0], 4'b0000};
  end

  assign db_oe   = (phase != PH_IDLE) & ~rw_q;
  assign lcd_rs  = rs_q;
  assign lcd_rw  = rw_q;
  assign rd_data = rd_q;

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter int CLK_MHZ      = 200,
  parameter int T_CYCLE_NS   = 500,
  parameter int T_EHIGH_NS   = 230,
  parameter int T_SETUP_NS   = 140,
  parameter int T_HOLD_NS    = 10,
  parameter int T_RDVALID_NS = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic       req_nibble,
  input  logic [7:0] req_data,
  output logic       req_ready,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [7:0] lcd_db_in
);

  localparam int CYC_CYC  = ns_to_clk(T_CYCLE_NS, CLK_MHZ);
  localparam int SU_CYC   = ns_to_clk(T_SETUP_NS, CLK_MHZ);
  localparam int HOLD_CYC = ns_to_clk(T_HOLD_NS, CLK_MHZ);
  localparam int HI_CYC   = max2(ns_to_clk(T_EHIGH_NS, CLK_MHZ),
                                 ns_to_clk(T_RDVALID_NS, CLK_MHZ) + 1);
  localparam int LO_CYC   = max2(HOLD_CYC, CYC_CYC - HI_CYC - SU_CYC);
  localparam int TW       = $clog2(max2(max2(SU_CYC, HI_CYC), LO_CYC) + 1);

  phase_e        phase;
  logic          second, nibble_mode, accept, sample;
  logic          load, expired;
  logic [TW-1:0] load_val;

  lcd_bus_seq #(
    .SU_CYC(SU_CYC), .HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_nibble(req_nibble),
    .expired(expired), .load(load), .load_val(load_val),
    .phase(phase), .second(second), .nibble_mode(nibble_mode),
    .accept(accept), .sample(sample), .ready(req_ready), .done(done)
  );

  lcd_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(load_val), .expired(expired)
  );

  lcd_data_lane u_lane (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data),
    .phase(phase), .second(second), .nibble_mode(nibble_mode),
    .sample(sample), .db_in(lcd_db_in),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .db_out(lcd_db_out),
    .db_oe(lcd_db_oe), .rd_data(rd_data)
  );

  assign lcd_e = (phase == PH_HIGH);

endmodule

// File: rtl/lcd_bus_checker.sv
module lcd_bus_checker #(
  parameter int SU_CYC   = 28,
  parameter int HI_CYC   = 46,
  parameter int CYC_CYC  = 100,
  parameter int HOLD_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lcd_e,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic [7:0] lcd_db_out,
  input logic       lcd_db_oe,
  input logic       req_ready,
  input logic       done
);

  localparam int CW = 16;
  localparam logic [CW-1:0] SAT = '1;

  logic [10:0]   bus_q;
  logic          rdy_q, e_q;
  logic [CW-1:0] hi_cnt, su_cnt, lo_cnt, r2r_cnt;
  logic          bus_chg, ctl_chg;

  assign bus_chg = ({lcd_rs, lcd_rw, lcd_db_out, lcd_db_oe} != bus_q);
  assign ctl_chg = bus_chg | (req_ready != rdy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      rdy_q   <= 1'b1;
      e_q     <= 1'b0;
      hi_cnt  <= '0;
      su_cnt  <= SAT;
      lo_cnt  <= SAT;
      r2r_cnt <= SAT;
    end else begin
      bus_q   <= {lcd_rs, lcd_rw, lcd_db_out, lcd_db_oe};
      rdy_q   <= req_ready;
      e_q     <= lcd_e;
      hi_cnt  <= lcd_e ? ((hi_cnt == SAT) ? SAT : hi_cnt + 1'b1) : '0;
      su_cnt  <= ctl_chg ? '0 : ((su_cnt == SAT) ? SAT : su_cnt + 1'b1);
      lo_cnt  <= lcd_e ? '0 : ((lo_cnt == SAT) ? SAT : lo_cnt + 1'b1);
      r2r_cnt <= (lcd_e && !e_q) ? '0 : ((r2r_cnt == SAT) ? SAT : r2r_cnt + 1'b1);
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lcd_e && !lcd_db_oe && !done);

  assert_strobe_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> !req_ready);

  assert_setup_met_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> su_cnt >= CW'(SU_CYC - 1));

  assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> hi_cnt >= CW'(HI_CYC));

  assert_stable_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> !bus_chg);

  assert_cycle_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> r2r_cnt >= CW'(CYC_CYC - 1));

  assert_hold_met_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_chg && !lcd_e && !e_q) |-> lo_cnt >= CW'(HOLD_CYC));

  assert_drive_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_db_oe |-> !lcd_rw);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

bind lcd_bus_engine lcd_bus_checker #(
  .SU_CYC(SU_CYC), .HI_CYC(HI_CYC), .CYC_CYC(CYC_CYC), .HOLD_CYC(HOLD_CYC)
) u_checker (
  .clk(clk), .rst_n(rst_n), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
  .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .req_ready(req_ready),
  .done(done)
);

// File: tb/lcd_bus_engine_tb.sv
module lcd_bus_engine_tb;

  localparam int MHZ = 200;
  localparam int SU  = (140 * MHZ + 999) / 1000;
  localparam int HI  = (230 * MHZ + 999) / 1000;
  localparam int CY  = (500 * MHZ + 999) / 1000;
  localparam int HO  = (10 * MHZ + 999) / 1000;
  localparam int STROBE = (SU + HI + HO > CY) ? SU + HI + HO : CY;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_rs, req_rw, req_nibble;
  logic [7:0] req_data;
  logic       req_ready, done;
  logic [7:0] rd_data;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] lcd_db_out, lcd_db_in;

  always #2.5 clk = ~clk;

  lcd_bus_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs),
    .req_rw(req_rw), .req_nibble(req_nibble), .req_data(req_data),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  int errors = 0;
  int checks = 0;

  // Monitor state, sampled on falling edges.
  int   t = 0;
  int   n_rise, n_done, n_acc, hold_viol, min_gap;
  int   rise_t [4];
  int   fall_w [4];
  int   acc_t  [4];
  int   done_t [4];
  logic [7:0] db_at  [4];
  logic       rs_at  [4];
  logic       rw_at  [4];
  logic       oe_at  [4];
  logic [7:0] resp   [4];
  int   t_fall;
  logic e_p, rdy_p;
  logic [10:0] bus_p;

  task automatic clear_stats();
    n_rise = 0; n_done = 0; n_acc = 0; hold_viol = 0; min_gap = 1 << 20;
    t_fall = -1000;
  endtask

  always @(negedge clk) begin
    t = t + 1;
    if (rst_n) begin
      if (rdy_p && !req_ready && n_acc < 4) begin
        acc_t[n_acc] = t; n_acc = n_acc + 1;
      end
      if (lcd_e && !e_p && n_rise < 4) begin
        if (n_rise > 0 && t - rise_t[n_rise-1] < min_gap) min_gap = t - rise_t[n_rise-1];
        rise_t[n_rise] = t;
        db_at[n_rise] = lcd_db_out; rs_at[n_rise] = lcd_rs;
        rw_at[n_rise] = lcd_rw;     oe_at[n_rise] = lcd_db_oe;
        lcd_db_in = resp[n_rise];
        n_rise = n_rise + 1;
      end
      if (!lcd_e && e_p && n_rise > 0) begin
        fall_w[n_rise-1] = t - rise_t[n_rise-1];
        t_fall = t;
      end
      if (!lcd_e && ({lcd_rs, lcd_rw, lcd_db_out, lcd_db_oe} != bus_p) && (t - t_fall < HO))
        hold_viol = hold_viol + 1;
      if (done && n_done < 4) begin
        done_t[n_done] = t; n_done = n_done + 1;
      end
    end
    e_p = lcd_e; rdy_p = req_ready;
    bus_p = {lcd_rs, lcd_rw, lcd_db_out, lcd_db_oe};
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic issue(input logic rs, input logic rw, input logic m4, input logic [7:0] d);
    @(negedge clk);
    req_rs = rs; req_rw = rw; req_nibble = m4; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!lcd_e,      "R1 enable low",  int'(lcd_e), 0);
    check(!lcd_db_oe,  "R1 oe low",      int'(lcd_db_oe), 0);
    check(req_ready,   "R1 ready high",  int'(req_ready), 1);
    check(!done,       "R1 done low",    int'(done), 0);
  endtask

  task automatic t_write8();
    clear_stats();
    issue(1'b1, 1'b0, 1'b0, 8'hA5);
    wait_done();
    check(n_rise == 1,              "R8 one strobe",      n_rise, 1);
    check(db_at[0] == 8'hA5,        "R8 byte driven",     db_at[0], 8'hA5);
    check(oe_at[0],                 "R8 oe on write",     int'(oe_at[0]), 1);
    check(rs_at[0] && !rw_at[0],    "R3 rs/rw write data", {rs_at[0], rw_at[0]}, 2);
    check(rise_t[0] - acc_t[0] == SU, "R4 setup clocks",  rise_t[0] - acc_t[0], SU);
    check(fall_w[0] == HI,          "R5 high width",      fall_w[0], HI);
    check(done_t[0] - acc_t[0] == STROBE, "R12 latency 8-bit", done_t[0] - acc_t[0], STROBE);
    check(hold_viol == 0,           "R7 hold",            hold_viol, 0);
  endtask

  task automatic t_write4();
    clear_stats();
    issue(1'b0, 1'b0, 1'b1, 8'h3C);
    wait_done();
    check(n_rise == 2,              "R9 two strobes",     n_rise, 2);
    check(db_at[0] == 8'h30,        "R9 upper first",     db_at[0], 8'h30);
    check(db_at[1] == 8'hC0,        "R9 lower second",    db_at[1], 8'hC0);
    check(!rs_at[0] && !rs_at[1],   "R3 rs instruction",  {rs_at[0], rs_at[1]}, 0);
    check(min_gap >= CY,            "R6 rise spacing",    min_gap, CY);
    check(done_t[0] - acc_t[0] == 2 * STROBE, "R12 latency 4-bit", done_t[0] - acc_t[0], 2 * STROBE);
    check(hold_viol == 0,           "R7 hold nibble",     hold_viol, 0);
  endtask

  task automatic t_read8();
    clear_stats();
    resp[0] = 8'h5A;
    issue(1'b1, 1'b1, 1'b0, 8'h00);
    wait_done();
    check(!oe_at[0],                "R8 bus released on read", int'(oe_at[0]), 0);
    check(rs_at[0] && rw_at[0],     "R3 rs/rw read data", {rs_at[0], rw_at[0]}, 3);
    check(rd_data == 8'h5A,         "R10 read byte",      rd_data, 8'h5A);
  endtask

  task automatic t_read4();
    clear_stats();
    resp[0] = 8'hB7; resp[1] = 8'h6F;
    issue(1'b0, 1'b1, 1'b1, 8'h00);
    wait_done();
    check(n_rise == 2,              "R11 two read strobes", n_rise, 2);
    check(rd_data == 8'hB6,         "R11 nibble assembly",  rd_data, 8'hB6);
    check(!rs_at[1] && rw_at[1],    "R3 status read lines", {rs_at[1], rw_at[1]}, 1);
  endtask

  task automatic t_busy_ignore();
    clear_stats();
    issue(1'b1, 1'b0, 1'b0, 8'h11);
    @(negedge clk);
    req_rs = 1'b0; req_data = 8'hEE; req_nibble = 1'b1; req_valid = 1'b1;
    repeat (40) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check(n_rise == 1,              "R2 no extra strobe", n_rise, 1);
    check(db_at[0] == 8'h11,        "R2 data unchanged",  db_at[0], 8'h11);
    check(rs_at[0] == 1'b1,         "R2 rs unchanged",    int'(rs_at[0]), 1);
    check(n_done == 1 && n_acc == 1, "R2 single transfer", n_done * 10 + n_acc, 11);
  endtask

  task automatic t_back2back();
    clear_stats();
    resp[1] = 8'h99;
    issue(1'b1, 1'b0, 1'b0, 8'h42);
    do @(negedge clk); while (!done);
    req_rs = 1'b1; req_rw = 1'b1; req_nibble = 1'b0; req_data = 8'h00; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check(n_done == 2,              "R12 two completions", n_done, 2);
    check(acc_t[1] - done_t[0] == 1, "R2 accept in done cycle", acc_t[1] - done_t[0], 1);
    check(min_gap >= CY,            "R6 spacing across transfers", min_gap, CY);
    check(rd_data == 8'h99,         "R10 read after write", rd_data, 8'h99);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd = wd + 1;
      if (wd > 150000) begin
        errors = errors + 1; checks = checks + 1;
        $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_rs = 1'b0; req_rw = 1'b0; req_nibble = 1'b0;
    req_data = 8'h00; lcd_db_in = 8'h00;
    for (int i = 0; i < 4; i++) resp[i] = 8'h00;
    clear_stats();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write8();
    t_write4();
    t_read8();
    t_read4();
    t_busy_ignore();
    t_back2back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule